// File: doc/BRIEF.md
# Four-Way Cache Tag and Replacement Controller

This block keeps the tag array and the replacement order for a four-way set-associative first-level cache. A requester presents an address on the lookup port. One cycle later the block reports a hit and the matching way, or a miss. On a miss it picks the least-recently-used way of the indexed set as the victim. In the same cycle it offers a line request, carrying that way number, to an external miss table. If the table accepts, the victim's tag is invalidated at once. If the victim held a live line, an eviction notice with the rebuilt line address goes out. If the table refuses (full or conflicting), the lookup reports retry and nothing in the array changes.

When the lower level returns the line, the fill port writes the tag into the way that was named in the request. A range flush walks from a start address in line-sized steps. At each step it invalidates a matching line, demotes it to least recently used, and reports it on the notice port. Each stored tag carries an exclusive-ownership flag, which the hit compare ignores. Data storage, the miss table and the next cache level live outside this block.

Top module: `tagc_ctrl`

## Requirements
- R1: An address splits into a byte offset (low log2(LINE_BYTES) bits), a set index (the next log2(SETS) bits) and a tag (all bits above). Lines differing only in offset map to the same entry.
- R2: An accepted lookup produces rsp_valid one cycle later. rsp_hit is 1 and rsp_way is the matching way when a valid way of the indexed set holds the request tag. The stored exclusive flag is ignored in this compare.
- R3: Replacement is true LRU per set. A lookup hit or a fill makes that way most recently used.
- R4: On a lookup miss, mt_req_valid is raised in the same cycle, together with mt_req_way (the set's least-recently-used way) and mt_req_addr (the request address with its offset bits cleared). rsp_way reports that victim.
- R5: If mt_refuse is high during a miss, rsp_retry is 1 and rsp_hit is 0. No tag, valid bit or LRU state changes, and no eviction notice is sent.
- R6: An accepted miss invalidates the victim way immediately. If that way held a valid line, ev_valid is raised the next cycle with ev_flush = 0 and ev_addr = {stored tag, set index, zero offset}, with the exclusive flag stripped.
- R7: A fill writes its tag and exclusive flag into fill_way of the indexed set, marks it valid and makes it most recently used. The target way must be invalid when the fill arrives.
- R8: A flush started with fl_start (when idle) processes addresses fl_addr, fl_addr+LINE_BYTES, ..., while they are below fl_addr+fl_size, one per cycle, with fl_busy high throughout. A size of zero performs no step.
- R9: At each flush step, a valid way whose tag matches is invalidated and made least recently used. ev_valid then rises the next cycle with ev_flush = 1 and the line address of that step.
- R10: lk_ready is 0 while a flush is in progress or a fill is presented. A fill presented during a flush pauses the flush for that cycle.
- R11: After reset all lines are invalid. The LRU order of every set, oldest first, is way 3, way 2, way 1, way 0. All response and notice outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_ready | output | 1 | Lookup can be taken this cycle |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_retry | output | 1 | Miss refused by the miss table |
| rsp_way | output | 2 | Hit way, or victim way on a miss |
| mt_req_valid | output | 1 | Line request to the miss table |
| mt_req_addr | output | ADDR_W | Requested line address |
| mt_req_way | output | 2 | Way the later fill must target |
| mt_refuse | input | 1 | Miss table refuses the request (full or conflict) |
| fill_valid | input | 1 | Install a returned line |
| fill_addr | input | ADDR_W | Address of the returned line |
| fill_way | input | 2 | Way recorded with the request |
| fill_excl | input | 1 | Exclusive flag stored with the tag |
| fl_start | input | 1 | Start a range flush |
| fl_addr | input | ADDR_W | Flush start address |
| fl_size | input | ADDR_W | Flush length in bytes |
| fl_busy | output | 1 | Flush in progress |
| ev_valid | output | 1 | Line-removal notice |
| ev_flush | output | 1 | Notice comes from a flush (1) or a miss eviction (0) |
| ev_addr | output | ADDR_W | Line address of the removed line |

## Verification
The bench fills every way of every set and then sweeps hits across all lines at varied offsets. This exposes a wrong index/tag split (hits in the wrong set) and a non-LRU victim choice (a wrong mt_req_way). Refused misses are followed by lookups of the old lines: a design that invalidated before the grant would lose a line and later miss. Lines filled with the exclusive flag must still hit and must be evicted with the flag stripped from ev_addr; a compare that kept the flag would turn those hits into misses. Flushes with unaligned starts, zero length and partial matches check the step count, and a later miss checks that the flushed way is chosen next. A design that skipped the demotion would evict a live line instead.

// File: rtl/tagc_pkg.sv
package tagc_pkg;
  localparam int WAYS  = 4;
  localparam int AGE_W = 6;
  typedef logic [1:0] way_t;

  // position of the pair (a,b), a<b, inside the age vector
  function automatic int pair_pos(int a, int b);
    if (a == 0) return b - 1;
    else if (a == 1) return b + 1;
    else return 5;
  endfunction

  // 1 when way a was used less recently than way b
  function automatic logic older(logic [AGE_W-1:0] m, int a, int b);
    if (a < b) return m[pair_pos(a, b)];
    else return !m[pair_pos(b, a)];
  endfunction

  // make way w the youngest (mru=1) or the oldest (mru=0)
  function automatic logic [AGE_W-1:0] age_update(logic [AGE_W-1:0] m, way_t w, logic mru);
    logic [AGE_W-1:0] r;
    r = m;
    for (int i = 0; i < WAYS; i++) begin
      if (i < int'(w)) r[pair_pos(i, int'(w))] = mru;
      else if (i > int'(w)) r[pair_pos(int'(w), i)] = !mru;
    end
    return r;
  endfunction

  function automatic way_t oldest_way(logic [AGE_W-1:0] m);
    way_t res;
    logic all_old;
    res = '0;
    for (int w = 0; w < WAYS; w++) begin
      all_old = 1'b1;
      for (int o = 0; o < WAYS; o++)
        if (o != w && !older(m, w, o)) all_old = 1'b0;
      if (all_old) res = way_t'(w);
    end
    return res;
  endfunction
endpackage

// File: rtl/tagc_tag_store.sv
module tagc_tag_store
  import tagc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [TAG_W-1:0] q_tag,
  output logic [WAYS-1:0]  q_hit,
  input  way_t             vic_way,
  output logic             vic_vld,
  output logic [TAG_W-1:0] vic_tag,
  input  logic [IDX_W-1:0] chk_idx,
  input  way_t             chk_way,
  output logic             chk_vld,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  way_t             w_way,
  input  logic             w_vld,
  input  logic [TAG_W:0]   w_tag
);
  // stored word: {exclusive flag, tag}
  logic [TAG_W:0]    tag_mem [SETS][WAYS];
  logic [WAYS-1:0]   vld_mem [SETS];

  always_ff @(posedge clk) begin
    if (we && w_vld) tag_mem[w_idx][w_way] <= w_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else if (we) begin
      vld_mem[w_idx][w_way] <= w_vld;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign q_hit[g] = vld_mem[q_idx][g] && (tag_mem[q_idx][g][TAG_W-1:0] == q_tag);
  end

  assign vic_vld = vld_mem[q_idx][vic_way];
  assign vic_tag = tag_mem[q_idx][vic_way][TAG_W-1:0];
  assign chk_vld = vld_mem[chk_idx][chk_way];
endmodule

// File: rtl/tagc_lru.sv
module tagc_lru
  import tagc_pkg::*;
#(
  parameter int SETS = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output way_t             lru_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  way_t             upd_way,
  input  logic             upd_mru
);
  logic [AGE_W-1:0] age_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (upd_en) begin
      age_q[upd_idx] <= age_update(age_q[upd_idx], upd_way, upd_mru);
    end
  end

  assign lru_way = oldest_way(age_q[rd_idx]);
endmodule

// File: rtl/tagc_flush_seq.sv
module tagc_flush_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] size,
  input  logic              step_en,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(LINE_BYTES);

  logic [ADDR_W:0] cur_q, end_q, nxt;
  logic            busy_q;

  assign nxt = cur_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
    end else if (!busy_q && start) begin
      cur_q  <= {1'b0, start_addr};
      end_q  <= {1'b0, start_addr} + {1'b0, size};
      busy_q <= (size != '0);
    end else if (busy_q && step_en) begin
      cur_q <= nxt;
      if (nxt >= end_q) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign cur_addr = cur_q[ADDR_W-1:0];
endmodule

// File: rtl/tagc_ctrl.sv
module tagc_ctrl
  import tagc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_retry,
  output logic [1:0]        rsp_way,
  output logic              mt_req_valid,
  output logic [ADDR_W-1:0] mt_req_addr,
  output logic [1:0]        mt_req_way,
  input  logic              mt_refuse,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_way,
  input  logic              fill_excl,
  input  logic              fl_start,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [ADDR_W-1:0] fl_size,
  output logic              fl_busy,
  output logic              ev_valid,
  output logic              ev_flush,
  output logic [ADDR_W-1:0] ev_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [ADDR_W-1:0] fl_cur, op_addr;
  logic [IDX_W-1:0]  op_idx, fill_idx;
  logic [TAG_W-1:0]  op_tag, fill_tag, vic_tag;
  logic [WAYS-1:0]   hit_vec;
  logic              hit_any, vic_vld, fill_tgt_vld;
  way_t              hit_way, lru_way;
  logic              lk_go, miss_go, miss_acc, fl_step, fl_match;

  logic              we, w_vld;
  logic [IDX_W-1:0]  w_idx;
  way_t              w_way;
  logic [TAG_W:0]    w_tag;
  logic              upd_en, upd_mru;
  logic [IDX_W-1:0]  upd_idx;
  way_t              upd_way;

  tagc_flush_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_flush (
    .clk(clk), .rst(rst), .start(fl_start), .start_addr(fl_addr), .size(fl_size),
    .step_en(!fill_valid), .busy(fl_busy), .cur_addr(fl_cur)
  );

  // one address path: the flush walker owns it while busy, lookups are stalled then
  assign op_addr  = fl_busy ? fl_cur : lk_addr;
  assign op_idx   = op_addr[OFF_W +: IDX_W];
  assign op_tag   = op_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[OFF_W +: IDX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  tagc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .q_idx(op_idx), .q_tag(op_tag), .q_hit(hit_vec),
    .vic_way(lru_way), .vic_vld(vic_vld), .vic_tag(vic_tag),
    .chk_idx(fill_idx), .chk_way(way_t'(fill_way)), .chk_vld(fill_tgt_vld),
    .we(we), .w_idx(w_idx), .w_way(w_way), .w_vld(w_vld), .w_tag(w_tag)
  );

  tagc_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst(rst), .rd_idx(op_idx), .lru_way(lru_way),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_way(upd_way), .upd_mru(upd_mru)
  );

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = way_t'(w);
  end
  assign hit_any = |hit_vec;

  assign lk_ready = !fl_busy && !fill_valid;
  assign lk_go    = lk_valid && lk_ready;
  assign miss_go  = lk_go && !hit_any;
  assign miss_acc = miss_go && !mt_refuse;
  assign fl_step  = fl_busy && !fill_valid;
  assign fl_match = fl_step && hit_any;

  assign mt_req_valid = miss_go;
  assign mt_req_addr  = {op_tag, op_idx, {OFF_W{1'b0}}};
  assign mt_req_way   = lru_way;

  // single tag write port: fill, victim invalidation, flush invalidation
  always_comb begin
    we    = 1'b0;
    w_idx = op_idx;
    w_way = lru_way;
    w_vld = 1'b0;
    w_tag = '0;
    if (fill_valid) begin
      we    = 1'b1;
      w_idx = fill_idx;
      w_way = way_t'(fill_way);
      w_vld = 1'b1;
      w_tag = {fill_excl, fill_tag};
    end else if (miss_acc) begin
      we = 1'b1;
    end else if (fl_match) begin
      we    = 1'b1;
      w_way = hit_way;
    end
  end

  always_comb begin
    upd_en  = 1'b0;
    upd_idx = op_idx;
    upd_way = hit_way;
    upd_mru = 1'b1;
    if (fill_valid) begin
      upd_en  = 1'b1;
      upd_idx = fill_idx;
      upd_way = way_t'(fill_way);
    end else if (lk_go && hit_any) begin
      upd_en = 1'b1;
    end else if (fl_match) begin
      upd_en  = 1'b1;
      upd_mru = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_way   <= '0;
      ev_valid  <= 1'b0;
      ev_flush  <= 1'b0;
      ev_addr   <= '0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go && hit_any;
      rsp_retry <= miss_go && mt_refuse;
      rsp_way   <= hit_any ? hit_way : lru_way;
      ev_valid  <= (miss_acc && vic_vld) || fl_match;
      ev_flush  <= fl_match;
      ev_addr   <= {(fl_match ? op_tag : vic_tag), op_idx, {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/tagc_ctrl_chk.sv
module tagc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_ready,
  input logic fl_busy,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_retry,
  input logic mt_req_valid,
  input logic fill_valid,
  input logic fill_tgt_vld,
  input logic ev_valid,
  input logic ev_flush
);
  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid && lk_ready));

  assert_req_only_on_lookup_R4: assert property (@(posedge clk) disable iff (rst)
    mt_req_valid |-> (lk_valid && lk_ready));

  assert_retry_not_hit_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_retry |-> (rsp_valid && !rsp_hit));

  assert_retry_no_evict_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_retry |-> !ev_valid);

  assert_evict_from_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_flush) |-> $past(mt_req_valid));

  assert_fill_target_free_R7: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !fill_tgt_vld);

  assert_flush_notice_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_flush) |-> $past(fl_busy));

  assert_stall_in_flush_R10: assert property (@(posedge clk) disable iff (rst)
    (fl_busy || fill_valid) |-> !lk_ready);
endmodule

bind tagc_ctrl tagc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .fl_busy(fl_busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry),
  .mt_req_valid(mt_req_valid), .fill_valid(fill_valid), .fill_tgt_vld(fill_tgt_vld),
  .ev_valid(ev_valid), .ev_flush(ev_flush)
);

// File: tb/tagc_ctrl_bench.sv
`timescale 1ns/1ps
module tagc_ctrl_bench;
  localparam int AW = 12;
  localparam int LB = 16;
  localparam int NS = 4;
  localparam int OW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, mt_refuse = 0, fill_valid = 0, fill_excl = 0, fl_start = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0, fl_addr = '0, fl_size = '0;
  logic [1:0] fill_way = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_retry, mt_req_valid, fl_busy, ev_valid, ev_flush;
  logic [1:0] rsp_way, mt_req_way;
  logic [AW-1:0] mt_req_addr, ev_addr;

  always #2.5 clk = ~clk;

  tagc_ctrl #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS)) u_tagc_ctrl (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry), .rsp_way(rsp_way),
    .mt_req_valid(mt_req_valid), .mt_req_addr(mt_req_addr), .mt_req_way(mt_req_way),
    .mt_refuse(mt_refuse), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_way(fill_way), .fill_excl(fill_excl), .fl_start(fl_start), .fl_addr(fl_addr),
    .fl_size(fl_size), .fl_busy(fl_busy), .ev_valid(ev_valid), .ev_flush(ev_flush),
    .ev_addr(ev_addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  int mtag [NS][4];
  bit mvld [NS][4];
  int stamp [NS][4];
  int ctr = 10;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      finish_run();
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mk(int tag, int idx, int off);
    return (tag << (OW + IW)) | (idx << OW) | off;
  endfunction
  function automatic int idx_of(int a); return (a >> OW) % NS; endfunction
  function automatic int tag_of(int a); return a >> (OW + IW); endfunction

  function automatic int m_lru(int s);
    int b = 0;
    for (int w = 1; w < 4; w++) if (stamp[s][w] < stamp[s][b]) b = w;
    return b;
  endfunction
  function automatic int m_hit(int s, int t);
    for (int w = 0; w < 4; w++) if (mvld[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic lookup(int addr, bit refuse, output int way_o);
    int s, t, hw, v;
    s = idx_of(addr); t = tag_of(addr);
    hw = m_hit(s, t); v = m_lru(s);
    @(negedge clk);
    lk_valid = 1; lk_addr = AW'(addr); mt_refuse = refuse;
    #1;
    check("R10", "lk_ready idle", int'(lk_ready), 1);
    check("R4", "mt_req_valid", int'(mt_req_valid), hw < 0 ? 1 : 0);
    if (hw < 0) begin
      check("R4", "mt_req_way (LRU victim)", int'(mt_req_way), v);
      check("R4", "mt_req_addr", int'(mt_req_addr), addr & ~(LB - 1));
    end
    @(negedge clk);
    lk_valid = 0; mt_refuse = 0;
    check("R2", "rsp_valid", int'(rsp_valid), 1);
    check("R2", "rsp_hit", int'(rsp_hit), hw >= 0 ? 1 : 0);
    check("R5", "rsp_retry", int'(rsp_retry), (hw < 0 && refuse) ? 1 : 0);
    check("R3", "rsp_way", int'(rsp_way), hw >= 0 ? hw : v);
    if (hw < 0 && !refuse && mvld[s][v]) begin
      check("R6", "ev_valid on eviction", int'(ev_valid), 1);
      check("R6", "ev_flush", int'(ev_flush), 0);
      check("R6", "ev_addr", int'(ev_addr), mk(mtag[s][v], s, 0));
    end else begin
      check("R6", "no notice", int'(ev_valid), 0);
    end
    if (hw >= 0) begin
      stamp[s][hw] = ++ctr; way_o = hw;
    end else begin
      if (!refuse) mvld[s][v] = 0;
      way_o = refuse ? -1 : v;
    end
  endtask

  task automatic fill(int addr, int way, bit excl);
    int s = idx_of(addr);
    @(negedge clk);
    fill_valid = 1; fill_addr = AW'(addr); fill_way = 2'(way); fill_excl = excl;
    lk_valid = 1; lk_addr = AW'(addr);
    #1;
    check("R10", "lk_ready during fill", int'(lk_ready), 0);
    @(negedge clk);
    fill_valid = 0; lk_valid = 0; fill_excl = 0;
    mvld[s][way] = 1; mtag[s][way] = tag_of(addr); stamp[s][way] = ++ctr;
  endtask

  task automatic miss_fill(int addr, bit excl);
    int w;
    lookup(addr, 0, w);
    if (w >= 0 && !mvld[idx_of(addr)][w]) fill(addr, w, excl);
  endtask

  task automatic flush(int start, int size);
    int n, a, s, t, hw;
    n = (size + LB - 1) / LB;
    @(negedge clk);
    fl_start = 1; fl_addr = AW'(start); fl_size = AW'(size);
    @(negedge clk);
    fl_start = 0;
    lk_valid = 1; lk_addr = AW'(start);
    #1;
    check("R8", "fl_busy at start", int'(fl_busy), n > 0 ? 1 : 0);
    if (n > 0) check("R10", "lk_ready during flush", int'(lk_ready), 0);
    lk_valid = 0;
    for (int k = 0; k < n; k++) begin
      a = (start + k * LB) % (1 << AW);
      s = idx_of(a); t = tag_of(a); hw = m_hit(s, t);
      if (hw >= 0) begin mvld[s][hw] = 0; stamp[s][hw] = -(++ctr); end
      @(negedge clk);
      check("R9", "flush notice", int'(ev_valid), hw >= 0 ? 1 : 0);
      if (hw >= 0) begin
        check("R9", "flush ev_flush", int'(ev_flush), 1);
        check("R9", "flush ev_addr", int'(ev_addr), a & ~(LB - 1));
      end
    end
    if (n == 0) @(negedge clk);
    check("R8", "fl_busy after last step", int'(fl_busy), 0);
    if (n == 0) check("R8", "no notice for empty flush", int'(ev_valid), 0);
  endtask

  initial begin
    int w;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) begin mvld[s][k] = 0; mtag[s][k] = 0; stamp[s][k] = 3 - k; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R11", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R11", "ev_valid after reset", int'(ev_valid), 0);
    check("R11", "fl_busy after reset", int'(fl_busy), 0);
    check("R11", "lk_ready after reset", int'(lk_ready), 1);

    // fill every way of every set; victims follow the reset order 3,2,1,0 (R11, R4, R7)
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) miss_fill(mk(k + 1, s, (k * 5) % LB), 0);

    // hit sweep over all lines at every third offset (R1, R2, R3)
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++)
        for (int off = 0; off < LB; off += 3) lookup(mk(k + 1, s, off), 0, w);

    // refused misses leave everything intact (R5)
    lookup(mk(20, 0, 0), 1, w);
    lookup(mk(21, 0, 7), 1, w);
    for (int k = 0; k < 4; k++) lookup(mk(k + 1, 0, 2), 0, w);

    // reorder set 3 by hits, then evict repeatedly (R3, R6)
    lookup(mk(2, 3, 0), 0, w);
    lookup(mk(4, 3, 0), 0, w);
    lookup(mk(1, 3, 0), 0, w);
    for (int k = 0; k < 6; k++) miss_fill(mk(30 + k, 3, k), 0);

    // exclusive flag ignored by compare and stripped from notices (R2, R6)
    miss_fill(mk(40, 2, 0), 1);
    lookup(mk(40, 2, 9), 0, w);
    for (int k = 0; k < 5; k++) miss_fill(mk(50 + k, 2, 0), 0);

    // flushes: aligned range, unaligned start, zero size, no matches (R8, R9)
    flush(mk(1, 0, 0), 4 * LB);
    flush(mk(52, 1, 5), 2 * LB + 1);
    flush(mk(53, 2, 0), 0);
    flush(mk(60, 0, 0), 3 * LB);
    flush(mk(31, 3, 3), LB);
    // the flushed ways must be chosen first (R9)
    miss_fill(mk(61, 0, 0), 0);
    miss_fill(mk(62, 3, 0), 0);
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 64; t += 7) lookup(mk(t, s, 1), 0, w);

    finish_run();
  end
endmodule